// File: doc/BRIEF.md
# Byte-Wide Multicycle Processor Datapath

This block is the data path of a small multicycle processor that executes 32-bit instructions over an 8-bit data path. It holds the program counter, a 32-bit instruction register filled one byte at a time from the memory read bus, and an eight-entry register file whose entry zero always reads as zero. It also holds four holding registers (memory data, two operand latches and the ALU output latch), the selectors that route operands, and an ALU with a zero flag.

An external control sequencer drives every select, enable and the 3-bit ALU operation code on each cycle. The datapath returns the instruction word, so the sequencer can decode it, and the zero flag, so branches can be resolved. It also drives the memory address and the data to store. Immediates and jump targets are cut to the low data byte, with a shift-by-two variant for each.

Top module: `bdp_datapath`

## Requirements
- R1: A synchronous active-high reset clears the PC, the instruction register and the four holding registers, so adr, instr and writedata read zero once reset is released.
- R2: When irwrite bit 3, 2, 1 or 0 is high at a clock edge, memdata is loaded into instr bits [31:24], [23:16], [15:8] or [7:0] respectively. Bytes whose bit is low keep their value, and several bits may load at the same edge.
- R3: The register file holds 7 writable 8-bit registers. The first read port is addressed by instr[23:21] and the second by instr[18:16], the low three bits of the 5-bit fields at [25:21] and [20:16]. A write happens at the edge where regwrite is high. The second port's value reaches writedata at the edge after it is read, with no write-through.
- R4: Register 0 reads as zero and a write to it has no effect.
- R5: The write index is instr[13:11] when regdst=1 and instr[18:16] when regdst=0.
- R6: The write value is the ALU output latch when memtoreg=0 and the memory data latch when memtoreg=1. The memory data latch holds memdata from the previous edge.
- R7: adr is the PC when iord=0 and the ALU output latch when iord=1, and it follows iord in the same cycle.
- R8: ALU operand A is the PC when alusrca=0 and the first operand latch when alusrca=1.
- R9: ALU operand B is selected by alusrcb: 00 the second operand latch, 01 the constant 1, 10 instr[7:0], 11 instr[5:0] followed by two zero bits.
- R10: alucont selects 010 add, 110 subtract, 000 AND, 001 OR, or 111 signed set-less-than (result 1 or 0). Arithmetic wraps modulo 256, and any other code gives 0. The ALU output latch takes the result at every edge.
- R11: zero is high in the same cycle exactly when the 8-bit ALU result is 0.
- R12: At an edge where pcen is high, the PC loads the value chosen by pcsource: 00 the ALU result, 01 the ALU output latch, 10 instr[5:0] followed by two zero bits, 11 the ALU result. With pcen low the PC holds, and the PC wraps at 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memdata | input | 8 | Byte read from memory |
| alusrca | input | 1 | ALU operand A select |
| memtoreg | input | 1 | Register write value select |
| iord | input | 1 | Memory address select |
| pcen | input | 1 | PC load enable |
| regwrite | input | 1 | Register file write enable |
| regdst | input | 1 | Register write index select |
| pcsource | input | 2 | Next PC select |
| alusrcb | input | 2 | ALU operand B select |
| irwrite | input | 4 | Per-byte instruction register load strobes |
| alucont | input | 3 | ALU operation code |
| zero | output | 1 | ALU result is zero |
| instr | output | 32 | Instruction register contents |
| adr | output | 8 | Memory address |
| writedata | output | 8 | Data to store, from the second operand latch |

## Verification
adr and zero are combinational and are read one time step after the inputs change, before the next edge. instr, the PC (seen on adr with iord=0) and the ALU output latch (seen on adr with iord=1) move at the first edge after their controls. A register write reaches writedata only at the second edge, one to write and one to load the operand latch, so the bench always lets one extra edge pass after a write or a read-index change. All inputs are driven and all outputs sampled on the falling edge. The ALU is swept over all five codes and 324 operand pairs, including the signed boundary values.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    localparam int DATA_W  = 8;
    localparam int INSTR_W = 32;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG  = 2'b00,
        SRCB_ONE  = 2'b01,
        SRCB_IMM  = 2'b10,
        SRCB_IMM4 = 2'b11
    } srcb_e;

    typedef enum logic [1:0] {
        PCN_ALU    = 2'b00,
        PCN_ALUOUT = 2'b01,
        PCN_JUMP   = 2'b10,
        PCN_ALT    = 2'b11
    } pcnext_e;

    // Low byte of a word, scaled by four within the byte.
    function automatic logic [DATA_W-1:0] scale4(input logic [DATA_W-1:0] v);
        return {v[DATA_W-3:0], 2'b00};
    endfunction

endpackage

// File: rtl/bdp_alu.sv
module bdp_alu
    import bdp_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/bdp_regfile.sv
module bdp_regfile #(
    parameter int WIDTH   = 8,
    parameter int REGBITS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [REGBITS-1:0] ra1,
    input  logic [REGBITS-1:0] ra2,
    input  logic [REGBITS-1:0] wa,
    input  logic [WIDTH-1:0]   wd,
    output logic [WIDTH-1:0]   rd1,
    output logic [WIDTH-1:0]   rd2
);

    localparam int NREG = 1 << REGBITS;

    logic [WIDTH-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (we && wa != '0) mem[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
    assign rd2 = (ra2 == '0) ? '0 : mem[ra2];

    // R3: a write to a nonzero index is found in storage at the next edge
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> (mem[$past(wa)] == $past(wd)));

endmodule

// File: rtl/bdp_instr_reg.sv
module bdp_instr_reg #(
    parameter int WIDTH  = 8,
    parameter int IWIDTH = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [IWIDTH/WIDTH-1:0] en,
    input  logic [WIDTH-1:0]        din,
    output logic [IWIDTH-1:0]       q
);

    localparam int NBYTES = IWIDTH / WIDTH;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)        q[k*WIDTH +: WIDTH] <= '0;
            else if (en[k]) q[k*WIDTH +: WIDTH] <= din;
        end
    end

    // R2: with no strobe the instruction word holds
    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |=> $stable(q));

endmodule

// File: rtl/bdp_datapath.sv
module bdp_datapath
    import bdp_pkg::*;
#(
    parameter int REGBITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   memdata,
    input  logic                alusrca,
    input  logic                memtoreg,
    input  logic                iord,
    input  logic                pcen,
    input  logic                regwrite,
    input  logic                regdst,
    input  logic [1:0]          pcsource,
    input  logic [1:0]          alusrcb,
    input  logic [3:0]          irwrite,
    input  logic [2:0]          alucont,
    output logic                zero,
    output logic [INSTR_W-1:0]  instr,
    output logic [DATA_W-1:0]   adr,
    output logic [DATA_W-1:0]   writedata
);

    localparam int W = DATA_W;

    logic [W-1:0] pc_q, mdr_q, a_q, b_q, aluout_q;
    logic [W-1:0] rd1, rd2, srca, srcb, alu_y, wb_data, pc_next;
    logic [REGBITS-1:0] ra1, ra2, wa;

    bdp_instr_reg #(.WIDTH(W), .IWIDTH(INSTR_W)) u_ir (
        .clk (clk),
        .rst (rst),
        .en  (irwrite),
        .din (memdata),
        .q   (instr)
    );

    assign ra1     = instr[RS_LSB +: REGBITS];
    assign ra2     = instr[RT_LSB +: REGBITS];
    assign wa      = regdst ? instr[RD_LSB +: REGBITS] : instr[RT_LSB +: REGBITS];
    assign wb_data = memtoreg ? mdr_q : aluout_q;

    bdp_regfile #(.WIDTH(W), .REGBITS(REGBITS)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (regwrite),
        .ra1 (ra1),
        .ra2 (ra2),
        .wa  (wa),
        .wd  (wb_data),
        .rd1 (rd1),
        .rd2 (rd2)
    );

    assign srca = alusrca ? a_q : pc_q;

    always_comb begin
        case (srcb_e'(alusrcb))
            SRCB_REG:  srcb = b_q;
            SRCB_ONE:  srcb = W'(1);
            SRCB_IMM:  srcb = instr[W-1:0];
            default:   srcb = scale4(instr[W-1:0]);
        endcase
    end

    bdp_alu #(.WIDTH(W)) u_alu (
        .op   (alucont),
        .a    (srca),
        .b    (srcb),
        .y    (alu_y),
        .zero (zero)
    );

    always_comb begin
        case (pcnext_e'(pcsource))
            PCN_ALUOUT: pc_next = aluout_q;
            PCN_JUMP:   pc_next = scale4(instr[W-1:0]);
            default:    pc_next = alu_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            mdr_q    <= memdata;
            a_q      <= rd1;
            b_q      <= rd2;
            aluout_q <= alu_y;
            if (pcen) pc_q <= pc_next;
        end
    end

    assign adr       = iord ? aluout_q : pc_q;
    assign writedata = b_q;

    // R1: reset leaves PC and ALU output latch cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && aluout_q == '0));

    // R12: PC holds while its enable is low
    assert_pc_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !pcen |=> $stable(pc_q));

    // R12: a jump target is always word aligned
    assert_jump_aligned_R12: assert property (@(posedge clk) disable iff (rst)
        (pcen && pcsource == 2'b10) |=> (pc_q[1:0] == 2'b00));

    // R4: reading index zero on the second port latches zero
    assert_r0_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (ra2 == '0) |=> (b_q == '0));

endmodule

// File: tb/tb_bdp_datapath.sv
module tb_bdp_datapath;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  memdata;
    logic        alusrca, memtoreg, iord, pcen, regwrite, regdst;
    logic [1:0]  pcsource, alusrcb;
    logic [3:0]  irwrite;
    logic [2:0]  alucont;
    logic        zero;
    logic [31:0] instr;
    logic [7:0]  adr, writedata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] iw = '0;

    always #4 clk = ~clk;

    bdp_datapath dut (
        .clk(clk), .rst(rst), .memdata(memdata), .alusrca(alusrca),
        .memtoreg(memtoreg), .iord(iord), .pcen(pcen), .regwrite(regwrite),
        .regdst(regdst), .pcsource(pcsource), .alusrcb(alusrcb),
        .irwrite(irwrite), .alucont(alucont), .zero(zero), .instr(instr),
        .adr(adr), .writedata(writedata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic load_byte(input int k, input logic [7:0] v);
        irwrite = 4'(1 << k);
        memdata = v;
        step();
        irwrite = '0;
        iw[k*8 +: 8] = v;
    endtask

    task automatic write_reg(input logic [4:0] idx, input logic [7:0] v);
        load_byte(1, {idx, 3'b000});
        memdata = v;
        step();
        regwrite = 1'b1; memtoreg = 1'b1; regdst = 1'b1;
        step();
        regwrite = 1'b0; memtoreg = 1'b0; regdst = 1'b0;
    endtask

    task automatic read_b(input logic [4:0] idx, input logic [7:0] exp, input string req);
        load_byte(2, {3'd1, idx});
        step();
        chk(req, {24'b0, writedata}, {24'b0, exp});
    endtask

    function automatic logic [7:0] exp_alu(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            3'b010:  return a + b;
            3'b110:  return a - b;
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b111:  return ($signed(a) < $signed(b)) ? 8'd1 : 8'd0;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] sweep_val(input int i);
        if (i < 16)  return 8'(i * 17);
        if (i == 16) return 8'h80;
        return 8'h7F;
    endfunction

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] ops [5] = '{3'b010, 3'b110, 3'b000, 3'b001, 3'b111};
        logic [7:0] v1;
        rst = 1'b1; memdata = '0; alusrca = 0; memtoreg = 0; iord = 0; pcen = 0;
        regwrite = 0; regdst = 0; pcsource = '0; alusrcb = '0; irwrite = '0;
        alucont = 3'b010;
        repeat (3) step();
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 adr", {24'b0, adr}, 32'h0);
        chk("R1 instr", instr, 32'h0);
        chk("R1 writedata", {24'b0, writedata}, 32'h0);
        chk("R11 zero after reset", {31'b0, zero}, 32'h1);

        // R2 byte strobes
        for (int k = 0; k < 4; k++) load_byte(k, 8'(32'hDEADBEEF >> (8*k)));
        chk("R2 full load", instr, 32'hDEADBEEF);
        load_byte(2, 8'h12);
        chk("R2 single byte", instr, 32'hDE12BEEF);
        irwrite = 4'b0101; memdata = 8'h77;
        step();
        irwrite = '0;
        chk("R2 two bytes", instr, 32'hDE77BE77);
        for (int k = 0; k < 4; k++) load_byte(k, 8'(32'h00220000 >> (8*k)));
        chk("R2 base word", instr, 32'h00220000);

        // R3 write and read every register
        for (int r = 1; r < 8; r++) write_reg(5'(r), 8'(r*37 + 5));
        for (int r = 0; r < 8; r++)
            read_b(5'(r), (r == 0) ? 8'h00 : 8'(r*37 + 5), "R3 register readback");
        // R4 register zero
        write_reg(5'd0, 8'hAA);
        read_b(5'd0, 8'h00, "R4 r0 ignores write");
        read_b(5'd1, 8'd42, "R4 r1 untouched by r0 write");

        // R5 regdst=0 writes the rt index
        write_reg(5'd6, 8'h11);
        load_byte(2, {3'd1, 5'd5});
        load_byte(1, {5'd6, 3'b000});
        memdata = 8'h3C;
        step();
        regwrite = 1; memtoreg = 1; regdst = 0;
        step();
        regwrite = 0; memtoreg = 0;
        read_b(5'd5, 8'h3C, "R5 rt index written");
        read_b(5'd6, 8'h11, "R5 rd index untouched");
        load_byte(2, 8'h22);

        // R6 memtoreg=0 writes the ALU output latch
        load_byte(0, 8'h13);
        load_byte(1, {5'd4, 3'b000});
        alucont = 3'b010; alusrca = 1; alusrcb = 2'b10;
        step();
        memdata = 8'hEE; regwrite = 1; memtoreg = 0; regdst = 1;
        step();
        regwrite = 0; regdst = 0;
        read_b(5'd4, 8'd42 + 8'h13, "R6 ALU latch written");
        load_byte(2, 8'h22);

        // R8 R9 operand selection, r1=42 on A, r2=79 on B
        v1 = 8'd42;
        for (int imm = 0; imm < 256; imm += 7) begin
            load_byte(0, 8'(imm));
            alusrca = 1; alusrcb = 2'b10;
            step();
            iord = 1; #1;
            chk("R9 imm operand", {24'b0, adr}, {24'b0, 8'(v1 + 8'(imm))});
            alusrcb = 2'b11;
            step();
            chk("R9 scaled imm operand", {24'b0, adr}, {24'b0, 8'(v1 + {imm[5:0], 2'b00})});
            iord = 0;
        end
        alusrcb = 2'b01; alusrca = 1;
        step(); iord = 1; #1;
        chk("R9 constant one", {24'b0, adr}, {24'b0, 8'd43});
        alusrcb = 2'b00;
        step();
        chk("R9 B latch operand", {24'b0, adr}, {24'b0, 8'd42 + 8'd79});
        alusrca = 0; alusrcb = 2'b01;
        step();
        chk("R8 PC operand", {24'b0, adr}, 32'h1);
        iord = 0; #1;
        chk("R7 adr from PC", {24'b0, adr}, 32'h0);
        load_byte(0, 8'h00);

        // R10 R11 ALU sweep
        for (int i = 0; i < 18; i++) begin
            for (int j = 0; j < 18; j++) begin
                write_reg(5'd1, sweep_val(i));
                write_reg(5'd2, sweep_val(j));
                alusrca = 1; alusrcb = 2'b00;
                step();
                for (int o = 0; o < 5; o++) begin
                    alucont = ops[o]; #1;
                    chk("R11 zero flag", {31'b0, zero},
                        {31'b0, exp_alu(ops[o], sweep_val(i), sweep_val(j)) == 8'd0});
                    step();
                    iord = 1; #1;
                    chk("R10 ALU result", {24'b0, adr},
                        {24'b0, exp_alu(ops[o], sweep_val(i), sweep_val(j))});
                    iord = 0;
                end
            end
        end
        alucont = 3'b011; #1;
        chk("R10 unused code zero flag", {31'b0, zero}, 32'h1);
        step(); iord = 1; #1;
        chk("R10 unused code result", {24'b0, adr}, 32'h0);
        iord = 0;

        // R12 PC sequencing and wrap
        alucont = 3'b010; alusrca = 0; alusrcb = 2'b01; pcsource = 2'b00; pcen = 1;
        for (int n = 1; n <= 260; n++) begin
            step();
            chk("R12 increment and wrap", {24'b0, adr}, {24'b0, 8'(n)});
        end
        pcen = 0; pcsource = 2'b10;
        step(); step();
        chk("R12 hold with enable low", {24'b0, adr}, 32'd4);
        pcsource = 2'b11; pcen = 1;
        step();
        pcen = 0;
        chk("R12 code 11 takes ALU result", {24'b0, adr}, 32'd5);
        for (int t = 0; t < 4; t++) begin
            logic [7:0] jv;
            jv = (t == 0) ? 8'h2D : (t == 1) ? 8'hFF : (t == 2) ? 8'h40 : 8'h01;
            load_byte(0, jv);
            pcsource = 2'b10; pcen = 1;
            step();
            pcen = 0;
            chk("R12 jump target", {24'b0, adr}, {24'b0, jv[5:0], 2'b00});
        end
        write_reg(5'd1, 8'h40);
        load_byte(0, 8'h13);
        alusrca = 1; alusrcb = 2'b10;
        step();
        alusrcb = 2'b01; pcsource = 2'b01; pcen = 1;
        step();
        pcen = 0;
        chk("R12 PC from ALU latch", {24'b0, adr}, 32'h53);
        iord = 1; #1;
        chk("R7 adr from ALU latch", {24'b0, adr}, 32'h41);
        iord = 0;

        // R1 reset in mid-run
        rst = 1;
        step();
        rst = 0; #1;
        chk("R1 reset PC", {24'b0, adr}, 32'h0);
        chk("R1 reset instr", instr, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule